// File: doc/BRIEF.md
# Interrupt Flag Aggregation Controller

This block gathers single-cycle event pulses from the protection and monitoring logic of a multi-regulator power device and turns each one into a sticky flag bit. Each regulator has three event sources: current limit, short circuit and output-good. Device-wide sources are thermal warning, thermal shutdown, supply overvoltage, GPIO edge, sync-clock change, load-measurement ready and restart. The restart flag is set by a reset-pin rising edge, by recovery from a supply undervoltage glitch, or by a software reset request. Software reads flags, masks and live condition bits through a simple word-wide register port. It acknowledges an event by writing a one to the flag's bit.

The active-low interrupt output is low whenever at least one flag is set and not masked. Short-circuit, thermal-shutdown and overvoltage flags have no mask, so they always reach the interrupt. The current-limit, thermal-warning, thermal-shutdown and overvoltage flags refuse acknowledgement while their condition input is still high. A new event always wins over an acknowledgement in the same cycle. A summary register gives one bit per regulator, so software can find the regulator to service with a single read.

Top module: `irq_flag_ctrl`

## Requirements
- R1: An event pulse sampled at a rising clock edge sets its flag, and the flag reads 1 from the next cycle on.
- R2: `irq_n` is low exactly when some flag is 1 while its mask bit is 0; with no such flag it is high.
- R3: A write to a flag register clears every flag whose data bit is 1; data bits of 0 leave their flags unchanged.
- R4: A clear of the current-limit, thermal-warning, thermal-shutdown or overvoltage flag has no effect while that flag's condition input is high.
- R5: When an event and a clear of the same flag arrive in the same cycle, the flag remains 1.
- R6: A masked flag still latches and reads back; the mask affects only `irq_n`.
- R7: The short-circuit, thermal-shutdown and overvoltage flags have no mask bit: their mask positions read 0 after any write, and these flags always pull `irq_n` low.
- R8: Status registers return the live condition inputs, not latched: device-wide bit 0 thermal warning, bit 1 thermal shutdown, bit 2 overvoltage, bit 4 sync clock; per regulator bit 0 current limit, bit 2 output good; all other bits read 0.
- R9: Summary bit i reads 1 while any flag of regulator i is set.
- R10: Each of `start_pin_rise`, `start_uvlo` and `start_sw` sets the restart flag.
- R11: After reset all flags and masks are 0 and `irq_n` is high.
- R12: Address map: 0 device flags, 1 device masks, 2 device status, 3 summary, then for regulator i: 4+3i flags, 5+3i masks, 6+3i status. Device flag and mask bits: 0 thermal warning, 1 thermal shutdown, 2 overvoltage, 3 GPIO, 4 sync, 5 load ready, 6 restart. Regulator bits: 0 current limit, 1 short circuit, 2 output good. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ilim_evt | input | NUM_REG | Current-limit event pulse per regulator |
| ilim_act | input | NUM_REG | Current-limit condition, live |
| sc_evt | input | NUM_REG | Short-circuit event pulse per regulator |
| pg_evt | input | NUM_REG | Output-good event pulse per regulator |
| pg_act | input | NUM_REG | Output-good condition, live |
| twarn_evt | input | 1 | Thermal warning event |
| twarn_act | input | 1 | Thermal warning condition |
| tsd_evt | input | 1 | Thermal shutdown event |
| tsd_act | input | 1 | Thermal shutdown condition |
| ovp_evt | input | 1 | Supply overvoltage event |
| ovp_act | input | 1 | Supply overvoltage condition |
| gpio_evt | input | 1 | GPIO edge event |
| sync_evt | input | 1 | Sync clock appeared or vanished |
| sync_act | input | 1 | Sync clock detector condition |
| ldrdy_evt | input | 1 | Load measurement ready |
| start_pin_rise | input | 1 | Start-up after reset-pin rising edge |
| start_uvlo | input | 1 | Start-up after undervoltage glitch |
| start_sw | input | 1 | Start-up after software reset request |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check the following on every cycle: an event sets its flag in the next cycle, a clear cannot take effect while a blocking condition is high, a flag falls only after a write with its bit set, and `irq_n` follows the set of pending unmaskable flags. The bench scenarios are needed to show the decode of the register map. They also cover mask bits that cannot be written, the live status values, the summary grouping per regulator, the three restart causes, and the interplay of masks with clears across several writes.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int DW     = 8;
    localparam int TOP_N  = 7;
    localparam int SUB_N  = 3;

    // device-wide bit positions
    localparam int TB_TWARN = 0;
    localparam int TB_TSD   = 1;
    localparam int TB_OVP   = 2;
    localparam int TB_GPIO  = 3;
    localparam int TB_SYNC  = 4;
    localparam int TB_LDRDY = 5;
    localparam int TB_RST   = 6;

    // per-regulator bit positions
    localparam int SB_ILIM = 0;
    localparam int SB_SC   = 1;
    localparam int SB_PG   = 2;

    localparam logic [TOP_N-1:0] TOP_MASKABLE = 7'b111_1001;
    localparam logic [TOP_N-1:0] TOP_HOLDABLE = 7'b000_0111;
    localparam logic [TOP_N-1:0] TOP_STATBITS = 7'b001_0111;
    localparam logic [SUB_N-1:0] SUB_MASKABLE = 3'b101;
    localparam logic [SUB_N-1:0] SUB_HOLDABLE = 3'b001;
    localparam logic [SUB_N-1:0] SUB_STATBITS = 3'b101;

    // address layout
    localparam int A_TOP_FLAG = 0;
    localparam int A_TOP_MASK = 1;
    localparam int A_TOP_STAT = 2;
    localparam int A_SUMMARY  = 3;
    localparam int A_REG_BASE = 4;
    localparam int REG_STRIDE = 3;

    function automatic int reg_addr(int idx, int off);
        return A_REG_BASE + REG_STRIDE * idx + off;
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int               W       = 3,
    parameter logic [W-1:0]     HOLD_EN = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] hold_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] flag_o
);
    typedef struct packed {
        logic [W-1:0] flag;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [W-1:0] clr_ok;

    always_comb begin
        st_d   = st_q;
        clr_ok = clr_data_i & {W{clr_we_i}} & ~(hold_i & HOLD_EN);
        // new events dominate any clear in the same cycle
        st_d.flag = set_i | (st_q.flag & ~clr_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int           W    = 3,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.mask = data_i & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int NUM_REG = 4,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REG-1:0] ilim_evt,
    input  logic [NUM_REG-1:0] ilim_act,
    input  logic [NUM_REG-1:0] sc_evt,
    input  logic [NUM_REG-1:0] pg_evt,
    input  logic [NUM_REG-1:0] pg_act,
    input  logic               twarn_evt,
    input  logic               twarn_act,
    input  logic               tsd_evt,
    input  logic               tsd_act,
    input  logic               ovp_evt,
    input  logic               ovp_act,
    input  logic               gpio_evt,
    input  logic               sync_evt,
    input  logic               sync_act,
    input  logic               ldrdy_evt,
    input  logic               start_pin_rise,
    input  logic               start_uvlo,
    input  logic               start_sw,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               irq_n
);
    localparam logic [ADDR_W-1:0] AD_TFLAG = ADDR_W'(A_TOP_FLAG);
    localparam logic [ADDR_W-1:0] AD_TMASK = ADDR_W'(A_TOP_MASK);
    localparam logic [ADDR_W-1:0] AD_TSTAT = ADDR_W'(A_TOP_STAT);
    localparam logic [ADDR_W-1:0] AD_SUMM  = ADDR_W'(A_SUMMARY);

    // device-wide sources
    logic [TOP_N-1:0] top_set, top_hold, top_stat, top_flag, top_mask;
    logic             top_flag_we, top_mask_we;

    // per-regulator sources
    logic [SUB_N-1:0]         reg_flag [NUM_REG];
    logic [SUB_N-1:0]         reg_mask [NUM_REG];
    logic [SUB_N-1:0]         reg_stat [NUM_REG];
    logic [NUM_REG-1:0]       summary;
    logic [NUM_REG-1:0]       reg_pend;
    logic [SUB_N*NUM_REG-1:0] reg_flag_flat;

    always_comb begin
        top_set           = '0;
        top_set[TB_TWARN] = twarn_evt;
        top_set[TB_TSD]   = tsd_evt;
        top_set[TB_OVP]   = ovp_evt;
        top_set[TB_GPIO]  = gpio_evt;
        top_set[TB_SYNC]  = sync_evt;
        top_set[TB_LDRDY] = ldrdy_evt;
        top_set[TB_RST]   = start_pin_rise | start_uvlo | start_sw;

        top_hold           = '0;
        top_hold[TB_TWARN] = twarn_act;
        top_hold[TB_TSD]   = tsd_act;
        top_hold[TB_OVP]   = ovp_act;

        top_stat           = '0;
        top_stat[TB_TWARN] = twarn_act;
        top_stat[TB_TSD]   = tsd_act;
        top_stat[TB_OVP]   = ovp_act;
        top_stat[TB_SYNC]  = sync_act;
        top_stat           = top_stat & TOP_STATBITS;
    end

    assign top_flag_we = wr_en && (addr == AD_TFLAG);
    assign top_mask_we = wr_en && (addr == AD_TMASK);

    irq_flag_bank #(.W(TOP_N), .HOLD_EN(TOP_HOLDABLE)) u_top_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (top_set),
        .hold_i     (top_hold),
        .clr_we_i   (top_flag_we),
        .clr_data_i (wdata[TOP_N-1:0]),
        .flag_o     (top_flag)
    );

    irq_mask_bank #(.W(TOP_N), .IMPL(TOP_MASKABLE)) u_top_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (top_mask_we),
        .data_i (wdata[TOP_N-1:0]),
        .mask_o (top_mask)
    );

    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] AD_F = ADDR_W'(reg_addr(i, 0));
        localparam logic [ADDR_W-1:0] AD_M = ADDR_W'(reg_addr(i, 1));

        logic [SUB_N-1:0] set_v, hold_v;
        logic             flag_we, mask_we;

        always_comb begin
            set_v          = '0;
            set_v[SB_ILIM] = ilim_evt[i];
            set_v[SB_SC]   = sc_evt[i];
            set_v[SB_PG]   = pg_evt[i];
            hold_v          = '0;
            hold_v[SB_ILIM] = ilim_act[i];
            reg_stat[i]          = '0;
            reg_stat[i][SB_ILIM] = ilim_act[i];
            reg_stat[i][SB_PG]   = pg_act[i];
            reg_stat[i]          = reg_stat[i] & SUB_STATBITS;
        end

        assign flag_we = wr_en && (addr == AD_F);
        assign mask_we = wr_en && (addr == AD_M);

        irq_flag_bank #(.W(SUB_N), .HOLD_EN(SUB_HOLDABLE)) u_flags (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (set_v),
            .hold_i     (hold_v),
            .clr_we_i   (flag_we),
            .clr_data_i (wdata[SUB_N-1:0]),
            .flag_o     (reg_flag[i])
        );

        irq_mask_bank #(.W(SUB_N), .IMPL(SUB_MASKABLE)) u_mask (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (mask_we),
            .data_i (wdata[SUB_N-1:0]),
            .mask_o (reg_mask[i])
        );

        assign summary[i]                     = |reg_flag[i];
        assign reg_pend[i]                    = |(reg_flag[i] & ~reg_mask[i]);
        assign reg_flag_flat[i*SUB_N +: SUB_N] = reg_flag[i];
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        if (addr == AD_TFLAG) rdata = DW'(top_flag);
        if (addr == AD_TMASK) rdata = DW'(top_mask);
        if (addr == AD_TSTAT) rdata = DW'(top_stat);
        if (addr == AD_SUMM)  rdata = DW'(summary);
        for (int i = 0; i < NUM_REG; i++) begin
            if (addr == ADDR_W'(reg_addr(i, 0))) rdata = DW'(reg_flag[i]);
            if (addr == ADDR_W'(reg_addr(i, 1))) rdata = DW'(reg_mask[i]);
            if (addr == ADDR_W'(reg_addr(i, 2))) rdata = DW'(reg_stat[i]);
        end
    end

    // unimplemented mask bits stay 0, so unmaskable flags always count
    assign irq_n = ~(|(top_flag & ~top_mask) | |reg_pend);
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
    import irq_flag_pkg::*;
#(
    parameter int NUM_REG = 4,
    parameter int ADDR_W  = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [DW-1:0]            wdata,
    input logic                     tsd_evt,
    input logic [NUM_REG-1:0]       ilim_evt,
    input logic [NUM_REG-1:0]       ilim_act,
    input logic                     twarn_act,
    input logic                     irq_n,
    input logic [TOP_N-1:0]         top_flag,
    input logic [SUB_N*NUM_REG-1:0] reg_flag_flat
);
    assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_evt |=> top_flag[TB_TSD]);

    assert_idle_irq_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (top_flag == '0 && reg_flag_flat == '0) |-> irq_n);

    assert_fall_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(top_flag[TB_TWARN]) |-> $past(wr_en && addr == ADDR_W'(A_TOP_FLAG) && wdata[TB_TWARN]));

    assert_twarn_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (twarn_act && top_flag[TB_TWARN]) |=> top_flag[TB_TWARN]);

    assert_tsd_unmaskable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        top_flag[TB_TSD] |-> !irq_n);

    for (genvar i = 0; i < NUM_REG; i++) begin : g_chk
        assert_ilim_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ilim_act[i] && reg_flag_flat[i*SUB_N+SB_ILIM]) |=> reg_flag_flat[i*SUB_N+SB_ILIM]);

        assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ilim_evt[i] |=> reg_flag_flat[i*SUB_N+SB_ILIM]);

        assert_sc_unmaskable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            reg_flag_flat[i*SUB_N+SB_SC] |-> !irq_n);
    end
endmodule

bind irq_flag_ctrl irq_flag_chk #(.NUM_REG(NUM_REG), .ADDR_W(ADDR_W)) u_irq_flag_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .tsd_evt       (tsd_evt),
    .ilim_evt      (ilim_evt),
    .ilim_act      (ilim_act),
    .twarn_act     (twarn_act),
    .irq_n         (irq_n),
    .top_flag      (top_flag),
    .reg_flag_flat (reg_flag_flat)
);

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;
    localparam int NR = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] ilim_evt = '0, ilim_act = '0, sc_evt = '0, pg_evt = '0, pg_act = '0;
    logic twarn_evt = 0, twarn_act = 0, tsd_evt = 0, tsd_act = 0, ovp_evt = 0, ovp_act = 0;
    logic gpio_evt = 0, sync_evt = 0, sync_act = 0, ldrdy_evt = 0;
    logic start_pin_rise = 0, start_uvlo = 0, start_sw = 0;
    logic          wr_en = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_flag_ctrl #(.NUM_REG(NR), .ADDR_W(AW)) i_irq_flag_ctrl (.*);

    // evt: 0 twarn,1 tsd,2 ovp,3 gpio,4 sync,5 ldrdy,6 start_sw
    // act: 0 twarn,1 tsd,2 ovp,3 sync
    typedef struct packed {
        logic [6:0] evt;
        logic [3:0] act;
        logic       wr;
        logic [5:0] waddr;
        logic [7:0] wdata;
        logic [5:0] raddr;
        logic [7:0] exp;
        logic       exp_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{7'h01, 4'h1, 1'b0, 6'd0, 8'h00, 6'd0,  8'h01, 1'b0, 4'd1 },  // R1 twarn sets
        '{7'h00, 4'h1, 1'b1, 6'd0, 8'h00, 6'd0,  8'h01, 1'b0, 4'd3 },  // R3 zero write
        '{7'h00, 4'h1, 1'b1, 6'd0, 8'h01, 6'd0,  8'h01, 1'b0, 4'd4 },  // R4 held
        '{7'h00, 4'h0, 1'b1, 6'd0, 8'h01, 6'd0,  8'h00, 1'b1, 4'd3 },  // R3 clear
        '{7'h00, 4'h0, 1'b1, 6'd1, 8'hFF, 6'd1,  8'h79, 1'b1, 4'd7 },  // R7 mask bits
        '{7'h08, 4'h0, 1'b0, 6'd0, 8'h00, 6'd0,  8'h08, 1'b1, 4'd6 },  // R6 masked latch
        '{7'h00, 4'h0, 1'b1, 6'd1, 8'h00, 6'd1,  8'h00, 1'b0, 4'd2 },  // R2 unmask
        '{7'h02, 4'h2, 1'b1, 6'd1, 8'hFF, 6'd0,  8'h0A, 1'b0, 4'd7 },  // R7 tsd
        '{7'h00, 4'h2, 1'b0, 6'd0, 8'h00, 6'd2,  8'h02, 1'b0, 4'd8 },  // R8 status
        '{7'h00, 4'h2, 1'b1, 6'd0, 8'h0A, 6'd0,  8'h02, 1'b0, 4'd4 },  // R4 partial
        '{7'h00, 4'h0, 1'b1, 6'd0, 8'h02, 6'd0,  8'h00, 1'b1, 4'd3 },  // R3
        '{7'h40, 4'h0, 1'b0, 6'd0, 8'h00, 6'd0,  8'h40, 1'b1, 4'd10},  // R10 sw
        '{7'h20, 4'h0, 1'b1, 6'd0, 8'h40, 6'd0,  8'h20, 1'b1, 4'd3 },  // R3
        '{7'h20, 4'h0, 1'b1, 6'd0, 8'h20, 6'd0,  8'h20, 1'b1, 4'd5 },  // R5
        '{7'h00, 4'h0, 1'b1, 6'd1, 8'h00, 6'd0,  8'h20, 1'b0, 4'd2 },  // R2
        '{7'h00, 4'h0, 1'b1, 6'd0, 8'h20, 6'd0,  8'h00, 1'b1, 4'd3 },  // R3
        '{7'h00, 4'h0, 1'b0, 6'd0, 8'h00, 6'd63, 8'h00, 1'b1, 4'd12},  // R12 unmapped
        '{7'h04, 4'h4, 1'b0, 6'd0, 8'h00, 6'd2,  8'h04, 1'b0, 4'd8 },  // R8 ovp
        '{7'h00, 4'h0, 1'b1, 6'd0, 8'h04, 6'd0,  8'h00, 1'b1, 4'd3 },  // R3
        '{7'h00, 4'h8, 1'b0, 6'd0, 8'h00, 6'd2,  8'h10, 1'b1, 4'd8 }   // R8 sync
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_pulses();
        ilim_evt = '0; sc_evt = '0; pg_evt = '0;
        twarn_evt = 0; tsd_evt = 0; ovp_evt = 0; gpio_evt = 0; sync_evt = 0;
        ldrdy_evt = 0; start_pin_rise = 0; start_uvlo = 0; start_sw = 0;
        wr_en = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_pulses();
    endtask

    task automatic wr(int a, logic [7:0] d);
        addr = AW'(a); wdata = d; wr_en = 1;
        step();
    endtask

    task automatic rd(int a, logic [7:0] exp, string req);
        addr = AW'(a);
        #1;
        check(req, 32'(rdata), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        rd(0, 8'h00, "R11 flags");
        rd(1, 8'h00, "R11 mask");
        check("R11 irq_n", 32'(irq_n), 32'd1);

        for (int v = 0; v < NV; v++) begin
            twarn_evt = VEC[v].evt[0]; tsd_evt = VEC[v].evt[1]; ovp_evt = VEC[v].evt[2];
            gpio_evt  = VEC[v].evt[3]; sync_evt = VEC[v].evt[4]; ldrdy_evt = VEC[v].evt[5];
            start_sw  = VEC[v].evt[6];
            twarn_act = VEC[v].act[0]; tsd_act = VEC[v].act[1];
            ovp_act   = VEC[v].act[2]; sync_act = VEC[v].act[3];
            addr = VEC[v].waddr; wdata = VEC[v].wdata; wr_en = VEC[v].wr;
            step();
            rd(int'(VEC[v].raddr), VEC[v].exp, $sformatf("R%0d vec%0d rdata", VEC[v].req, v));
            check($sformatf("R%0d vec%0d irq_n", VEC[v].req, v), 32'(irq_n), 32'(VEC[v].exp_irq));
        end
        twarn_act = 0; tsd_act = 0; ovp_act = 0; sync_act = 0;

        // R10 other restart causes
        start_pin_rise = 1; step();
        rd(0, 8'h40, "R10 pin rise");
        wr(0, 8'h40);
        start_uvlo = 1; step();
        rd(0, 8'h40, "R10 uvlo");
        wr(0, 8'h40);
        rd(0, 8'h00, "R10 cleared");

        // regulator 2: flags 10, mask 11, status 12
        ilim_evt[2] = 1; ilim_act[2] = 1; step();
        rd(10, 8'h01, "R1 reg2 ilim");
        check("R2 reg2 irq_n", 32'(irq_n), 32'd0);
        rd(3, 8'h04, "R9 summary reg2");
        rd(12, 8'h01, "R8 reg2 status");
        wr(10, 8'h01);
        rd(10, 8'h01, "R4 reg2 ilim held");
        ilim_act[2] = 0;
        wr(10, 8'h01);
        rd(10, 8'h00, "R3 reg2 ilim clear");
        rd(3, 8'h00, "R9 summary clear");
        check("R2 irq released", 32'(irq_n), 32'd1);

        // regulator 1: flags 7, mask 8
        wr(8, 8'hFF);
        rd(8, 8'h05, "R7 reg1 mask bits");
        sc_evt[1] = 1; pg_evt[1] = 1; pg_act[1] = 1; step();
        rd(7, 8'h06, "R6 reg1 flags");
        check("R7 sc irq_n", 32'(irq_n), 32'd0);
        rd(9, 8'h04, "R8 reg1 pg status");
        rd(3, 8'h02, "R9 summary reg1");
        wr(7, 8'h02);
        rd(7, 8'h04, "R3 reg1 sc clear");
        check("R6 masked pg irq_n", 32'(irq_n), 32'd1);
        pg_act[1] = 0;

        // R11 reset in mid-run
        gpio_evt = 1; step();
        wr(1, 8'h08);
        rst_n = 0; step(); step(); rst_n = 1; step();
        rd(0, 8'h00, "R11 flags after reset");
        rd(1, 8'h00, "R11 mask after reset");
        rd(7, 8'h00, "R11 reg flags after reset");
        check("R11 irq_n after reset", 32'(irq_n), 32'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule